// File: doc/BRIEF.md
# Order-Compatible Parent-Set Scoring Core

The core scores one node of a probabilistic network against one local order. A list of candidate parent sets is preloaded, each as a bitmask over the possible parents together with a signed fixed-point log score. When a start strobe arrives with an order row, the core replays the whole list from its first entry. It keeps only the sets whose masks fit inside the row and sums their scores in the log domain, that is, a log-sum-exp built from a small correction table. In the same pass it records the best compatible set, which a graph sampler uses.

The summing datapath is pipelined and shared in turn by four scoring threads, so one list entry is consumed every cycle. The thread partial sums are merged one after another once the list is exhausted. The scan time depends only on how many entries are loaded, so cores loaded with equal counts finish together. A core with an empty list reports itself as bypassed.

Top module: `pset_score_core`

## Requirements
- R1: Entry i is compatible with order row O when (mask_i & ~O) == 0. Only compatible entries take part in the sum and in the best-set search. An all-zero mask is compatible with every row.
- R2: Scores are in units of 1/4 of a log2 step. Two values a and b combine as max(a,b) + T(|a-b|). For gaps 0 to 13, T is 4,4,3,3,2,2,2,2,1,1,1,1,1,1; for gaps of 14 or more, T is 0.
- R3: Compatible entry i goes to thread i mod 4. Each thread folds its entries in ascending index order, and its first entry is taken unchanged. After the scan, the non-empty thread partials are folded in thread order 0, 1, 2, 3.
- R4: Every start replays entries 0 to N-1 from the beginning, where N is the number loaded. Repeating an order repeats the result exactly. ld_valid appends one entry, and ld_clr empties the list.
- R5: For a start sampled at clock edge 0, busy is high after edge 0. res_valid is a one-cycle pulse after edge N+6, and busy falls on that same edge.
- R6: best_mask and best_score give the compatible entry with the highest score. Among equal scores the lowest index wins. best_valid is 1 when at least one entry is compatible.
- R7: When no entry is compatible, res_sum is -32768 and best_valid is 0.
- R8: bypass is high exactly when the list is empty. A start on an empty list still yields res_valid after 6 cycles, with res_sum -32768.
- R9: While busy, start, ld_valid and ld_clr are ignored. The running scan uses the order sampled at its own start.
- R10: Once DEPTH (32) entries are held, further loads are dropped.
- R11: After reset: busy 0, res_valid 0, bypass 1, res_sum -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_clr | input | 1 | Empty the parent-set list (idle only) |
| ld_valid | input | 1 | Append one entry (idle only) |
| ld_mask | input | NW | Parent mask of the appended entry |
| ld_score | input | SW | Signed log score of the appended entry |
| start | input | 1 | Begin scoring against `order` |
| order | input | NW | Local-order row: parents allowed for this node |
| busy | output | 1 | Scan or merge in progress |
| res_valid | output | 1 | One-cycle pulse: results ready |
| res_sum | output | SW | Log-domain sum of compatible scores |
| best_valid | output | 1 | At least one compatible entry |
| best_mask | output | NW | Mask of best compatible entry |
| best_score | output | SW | Score of best compatible entry |
| bypass | output | 1 | List empty, core disabled |

## Verification
The best-set search and the log-domain sum are updated for the same entry, and a tie in the search can land in the cycle a thread takes its first value. Directed lists with duplicated top scores and with all-zero masks provoke both at once. Both outputs are judged against a bench model that follows the fold order in R3. A second overlap comes from start and load requests that land mid-scan. These are injected three cycles into a run, and they are judged by an unchanged latency and result, followed by a rerun that must match the model list.

// File: rtl/pset_score_core.sv
module pset_score_core #(
  parameter int NW    = 8,
  parameter int SW    = 16,
  parameter int DEPTH = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_clr,
  input  logic          ld_valid,
  input  logic [NW-1:0] ld_mask,
  input  logic [SW-1:0] ld_score,
  input  logic          start,
  input  logic [NW-1:0] order,
  output logic          busy,
  output logic          res_valid,
  output logic [SW-1:0] res_sum,
  output logic          best_valid,
  output logic [NW-1:0] best_mask,
  output logic [SW-1:0] best_score,
  output logic          bypass
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  function automatic logic [2:0] corr(input logic [SW:0] d);
    if (d > (SW+1)'(13)) return 3'd0;
    case (d[3:0])
      4'd0, 4'd1:             return 3'd4;
      4'd2, 4'd3:             return 3'd3;
      4'd4, 4'd5, 4'd6, 4'd7: return 3'd2;
      default:                return 3'd1;
    endcase
  endfunction

  function automatic logic signed [SW-1:0] maxs(input logic signed [SW-1:0] a, b);
    return (a >= b) ? a : b;
  endfunction

  function automatic logic [SW:0] gap(input logic signed [SW-1:0] a, b);
    return (a >= b) ? ({a[SW-1], a} - {b[SW-1], b}) : ({b[SW-1], b} - {a[SW-1], a});
  endfunction

  function automatic logic signed [SW-1:0] ladd(input logic signed [SW-1:0] a, b);
    return maxs(a, b) + $signed({{(SW-3){1'b0}}, corr(gap(a, b))});
  endfunction

  logic [NW-1:0]        mmask  [DEPTH];
  logic signed [SW-1:0] mscore [DEPTH];
  logic [CW-1:0]        cnt;

  logic                 run;
  logic [CW-1:0]        idx;
  logic [NW-1:0]        ord_q;
  logic                 s0_v, s1_v, s1_first;
  logic [1:0]           s0_t, s1_t;
  logic [NW-1:0]        s0_m;
  logic signed [SW-1:0] s0_s, s1_mx;
  logic [SW:0]          s1_d;
  logic signed [SW-1:0] acc [4];
  logic [3:0]           av;
  logic [2:0]           mcnt;
  logic [1:0]           mj;
  logic signed [SW-1:0] res_q, bs_q;
  logic                 res_v;

  wire load_ok = !busy && !ld_clr && ld_valid && (cnt != FULL);
  wire compat  = s0_v && ((s0_m & ~ord_q) == '0);
  wire s0_has  = av[s0_t];
  assign mj    = 2'(mcnt - 3'd2);

  assign bypass     = (cnt == '0);
  assign res_sum    = res_v ? res_q : SMIN;
  assign best_score = bs_q;

  always_ff @(posedge clk)
    if (load_ok) begin
      mmask[cnt[IW-1:0]]  <= ld_mask;
      mscore[cnt[IW-1:0]] <= ld_score;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    cnt <= '0;
    else if (!busy && ld_clr)      cnt <= '0;
    else if (load_ok)              cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; run <= 1'b0; idx <= '0; ord_q <= '0;
      s0_v <= 1'b0; s0_t <= '0; s0_m <= '0; s0_s <= '0;
      s1_v <= 1'b0; s1_t <= '0; s1_first <= 1'b0; s1_mx <= '0; s1_d <= '0;
      for (int t = 0; t < 4; t++) acc[t] <= '0;
      av <= '0; mcnt <= '0; res_q <= '0; res_v <= 1'b0; res_valid <= 1'b0;
      best_valid <= 1'b0; best_mask <= '0; bs_q <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; run <= 1'b1; idx <= '0; ord_q <= order;
        av <= '0; res_v <= 1'b0; best_valid <= 1'b0;
      end

      s0_v <= 1'b0;
      if (run) begin
        if (idx == cnt) begin
          run  <= 1'b0;
          mcnt <= 3'd1;
        end else begin
          s0_v <= 1'b1;
          s0_t <= idx[1:0];
          s0_m <= mmask[idx[IW-1:0]];
          s0_s <= mscore[idx[IW-1:0]];
          idx  <= idx + 1'b1;
        end
      end

      s1_v     <= compat;
      s1_t     <= s0_t;
      s1_first <= !s0_has;
      s1_mx    <= s0_has ? maxs(acc[s0_t], s0_s) : s0_s;
      s1_d     <= s0_has ? gap(acc[s0_t], s0_s) : '0;
      if (compat && (!best_valid || s0_s > bs_q)) begin
        best_valid <= 1'b1;
        best_mask  <= s0_m;
        bs_q       <= s0_s;
      end

      if (s1_v) begin
        acc[s1_t] <= s1_first ? s1_mx : s1_mx + $signed({{(SW-3){1'b0}}, corr(s1_d)});
        av[s1_t]  <= 1'b1;
      end

      if (mcnt != 3'd0) begin
        mcnt <= mcnt + 3'd1;
        if (mcnt >= 3'd2 && av[mj]) begin
          res_q <= res_v ? ladd(res_q, acc[mj]) : acc[mj];
          res_v <= 1'b1;
        end
        if (mcnt == 3'd5) begin
          mcnt      <= 3'd0;
          busy      <= 1'b0;
          res_valid <= 1'b1;
        end
      end
    end
  end
endmodule

module pset_score_core_chk #(
  parameter int NW = 8,
  parameter int SW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          res_valid,
  input logic [SW-1:0] res_sum,
  input logic          best_valid,
  input logic [NW-1:0] best_mask,
  input logic [SW-1:0] best_score,
  input logic [NW-1:0] ord_q
);
  localparam logic [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);
  assert_best_compat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && best_valid) |-> ((best_mask & ~ord_q) == '0));
  assert_empty_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !best_valid) |-> (res_sum == SMIN));
  assert_sum_ge_best_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && best_valid) |-> ($signed(res_sum) >= $signed(best_score)));
  assert_order_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ord_q));
endmodule

bind pset_score_core pset_score_core_chk #(.NW(NW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .res_valid(res_valid),
  .res_sum(res_sum), .best_valid(best_valid), .best_mask(best_mask),
  .best_score(best_score), .ord_q(ord_q));

// File: tb/test_pset_score_core.sv
`timescale 1ns/1ps
module test_pset_score_core;
  localparam int NW = 8, SW = 16, DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic ld_clr = 0, ld_valid = 0, start = 0;
  logic [NW-1:0] ld_mask = '0, order = '0;
  logic signed [SW-1:0] ld_score = '0;
  logic busy, res_valid, best_valid, bypass;
  logic signed [SW-1:0] res_sum, best_score;
  logic [NW-1:0] best_mask;

  pset_score_core #(.NW(NW), .SW(SW), .DEPTH(DEPTH)) i_pset_score_core (
    .clk(clk), .rst_n(rst_n), .ld_clr(ld_clr), .ld_valid(ld_valid),
    .ld_mask(ld_mask), .ld_score(ld_score), .start(start), .order(order),
    .busy(busy), .res_valid(res_valid), .res_sum(res_sum),
    .best_valid(best_valid), .best_mask(best_mask), .best_score(best_score),
    .bypass(bypass));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int m_mask [DEPTH];
  int m_score [DEPTH];
  int m_n = 0;
  int tbl [14] = '{4, 4, 3, 3, 2, 2, 2, 2, 1, 1, 1, 1, 1, 1};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lsum(input int a, input int b);
    int hi = (a > b) ? a : b;
    int g  = (a > b) ? a - b : b - a;
    return hi + ((g < 14) ? tbl[g] : 0);
  endfunction

  task automatic model(input int ord, output int s, output int bv, output int bm, output int bs);
    int part [4];
    bit has [4];
    bit any = 0;
    for (int t = 0; t < 4; t++) has[t] = 0;
    bv = 0; bm = 0; bs = 0;
    for (int i = 0; i < m_n; i++)
      if ((m_mask[i] & ~ord & 8'hff) == 0) begin
        part[i % 4] = has[i % 4] ? lsum(part[i % 4], m_score[i]) : m_score[i];
        has[i % 4] = 1;
        if (bv == 0 || m_score[i] > bs) begin bv = 1; bm = m_mask[i]; bs = m_score[i]; end
      end
    s = -32768;
    for (int t = 0; t < 4; t++)
      if (has[t]) begin s = any ? lsum(s, part[t]) : part[t]; any = 1; end
  endtask

  task automatic clr();
    @(negedge clk); ld_clr = 1;
    @(negedge clk); ld_clr = 0;
    m_n = 0;
  endtask

  task automatic ld(input int mask, input int score);
    @(negedge clk); ld_valid = 1; ld_mask = mask[NW-1:0]; ld_score = score[SW-1:0];
    @(negedge clk); ld_valid = 0;
    if (m_n < DEPTH) begin m_mask[m_n] = mask & 8'hff; m_score[m_n] = score; m_n++; end
  endtask

  task automatic go(input int ord, input bit poke, input string tag);
    int es, ebv, ebm, ebs, lat;
    model(ord, es, ebv, ebm, ebs);
    @(negedge clk); order = ord[NW-1:0]; start = 1;
    @(negedge clk); start = 0; order = ~ord[NW-1:0];
    chk({tag, " R5 busy"}, int'(busy), 1);
    lat = 0;
    while (!res_valid && lat < 2000) begin
      @(negedge clk); lat++;
      if (poke && lat == 3) begin
        start = 1; order = NW'($urandom);
        ld_valid = 1; ld_clr = 1; ld_mask = NW'($urandom); ld_score = -16'sd5;
      end else begin
        start = 0; ld_valid = 0; ld_clr = 0;
      end
    end
    chk({tag, " R5 latency"}, lat, m_n + 6);
    chk({tag, " R2 R3 sum"}, int'(res_sum), es);
    chk({tag, " R6 best_valid"}, int'(best_valid), ebv);
    if (ebv != 0) begin
      chk({tag, " R6 best_mask"}, int'(best_mask), ebm);
      chk({tag, " R6 best_score"}, int'(best_score), ebs);
    end
    @(negedge clk);
    chk({tag, " R5 pulse"}, int'(res_valid), 0);
    chk({tag, " R5 idle"}, int'(busy), 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R11 busy", int'(busy), 0);
    chk("R11 res_valid", int'(res_valid), 0);
    chk("R11 bypass", int'(bypass), 1);
    chk("R11 res_sum", int'(res_sum), -32768);
    rst_n = 1;
    @(negedge clk);

    go(8'hff, 0, "R8 empty");
    chk("R8 bypass", int'(bypass), 1);

    ld(8'h00, -40); ld(8'h03, -10); ld(8'h01, -10); ld(8'h80, -2);
    ld(8'h00, -10); ld(8'h05, -60); ld(8'h02, -9);  ld(8'h00, -41);
    ld(8'h10, -3);  ld(8'h03, -12);
    chk("R8 loaded", int'(bypass), 0);
    go(8'hff, 0, "R1 all");
    go(8'h00, 0, "R1 zero-mask");
    go(8'h03, 0, "R6 tie");
    go(8'h03, 0, "R4 replay");
    go(8'h01, 1, "R9 poke");
    go(8'h01, 0, "R9 rerun");

    clr();
    ld(8'h01, -5); ld(8'h02, -6); ld(8'h04, -7);
    go(8'h00, 0, "R7 none");
    go(8'h08, 0, "R7 none2");

    clr();
    for (int i = 0; i < DEPTH + 3; i++) ld(int'($urandom & $urandom & 8'hff), -int'($urandom % 3000));
    go(8'hff, 0, "R10 full");
    go(int'($urandom | $urandom) & 8'hff, 0, "R10 part");

    for (int r = 0; r < 6; r++) begin
      int n = 1 + int'($urandom % DEPTH);
      clr();
      for (int i = 0; i < n; i++) ld(int'($urandom & $urandom & 8'hff), -1 - int'($urandom % 40));
      for (int k = 0; k < 4; k++) go(int'($urandom | $urandom) & 8'hff, 0, "R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule